// File: doc/BRIEF.md
# Register Rename Unit with Commit-Time Recovery Map

This block performs explicit register renaming for an out-of-order core. Each architectural register is mapped onto a larger pool of physical registers. Every instruction that writes a register receives a fresh physical destination. This removes write-after-read and write-after-write hazards between instructions that reuse the same architectural name.

The block keeps two mapping tables and a pool of unused physical registers. The front map is read and written at rename and reflects speculative state. The commit map is written only when an instruction retires, and it holds the committed architectural state. The pool is a FIFO of unallocated physical registers. At commit, the physical register that the committing destination displaces in the commit map goes back into the pool. A flush copies the commit map into the front map in a single cycle. It also rebuilds the pool from every physical register that the commit map does not reference. Register values and ready bits are held outside this block.

Top module: `rat_rename`

## Requirements
- R1: After reset, both maps send architectural register i to physical register i (0..31), and the pool hands out physical registers 32 to 63 in ascending order.
- R2: Source lookups are combinational reads of the front map. When the source equals the destination of the same rename, the lookup returns the mapping that held before that rename.
- R3: A rename that fires with a destination write enable and a nonzero destination takes the head of the pool as `ren_pd`. It then points that destination at `ren_pd` in the front map from the next cycle.
- R4: A rename with destination 0 or with the write enable low allocates nothing, reports `ren_pd` as 0 and leaves the front map and the pool unchanged.
- R5: `ren_ready` is low when a rename needs a destination and the pool is empty. A rename that is not ready changes no state.
- R6: A commit with a nonzero destination writes `cmt_pd` into the commit map for that destination. It pushes the physical register previously held there onto the tail of the pool.
- R7: A commit whose destination is 0 has no effect.
- R8: On `flush`, the front map becomes the commit map, including any commit in the same cycle. The pool is rebuilt as the unreferenced physical registers in ascending order, `ren_ready` is low and no rename fires in that cycle.
- R9: The pool is first-in first-out. Registers released by commits are handed out after the ones already waiting, in the order they were released.
- R10: Architectural register 0 always reads as physical register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request |
| ren_rd_we | input | 1 | Rename has a destination |
| ren_rs1 | input | 5 | First source architectural register |
| ren_rs2 | input | 5 | Second source architectural register |
| ren_rd | input | 5 | Destination architectural register |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_ps1 | output | 6 | First source physical register |
| ren_ps2 | output | 6 | Second source physical register |
| ren_pd | output | 6 | Allocated physical destination, 0 if none |
| cmt_valid | input | 1 | Commit request |
| cmt_rd | input | 5 | Committing destination architectural register |
| cmt_pd | input | 6 | Committing destination physical register |
| flush | input | 1 | Restore speculative state from commit state |

## Verification
Every cycle, the assertions check the following. The pool never pops when empty and never overflows. Physical register 0 is never allocated. A commit lands in the commit map on the next cycle. The front map equals the commit map right after a flush. The allocation order, stall timing, the pre-update source read, flush rebuild order and the ignored x0 commits are shown only by the bench. Its reference model of both maps and the pool is driven by random rename, commit and flush traffic, plus directed pool exhaustion.

// File: rtl/rat_pkg.sv
package rat_pkg;
  parameter int unsigned RAT_NUM_ARCH = 32;
  parameter int unsigned RAT_NUM_PHYS = 64;
  localparam int unsigned RAT_AW = $clog2(RAT_NUM_ARCH);
  localparam int unsigned RAT_PW = $clog2(RAT_NUM_PHYS);
endpackage

// File: rtl/rat_map_table.sv
module rat_map_table #(
  parameter int unsigned NA = 32,
  parameter int unsigned NP = 64,
  localparam int unsigned AW = $clog2(NA),
  localparam int unsigned PW = $clog2(NP)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_idx,
  input  logic [PW-1:0]          wr_val,
  input  logic                   load_en,
  input  logic [NA-1:0][PW-1:0]  load_val,
  output logic [NA-1:0][PW-1:0]  map_q,
  output logic [NA-1:0][PW-1:0]  map_next
);

  always_comb begin
    map_next = map_q;
    if (load_en) begin
      map_next = load_val;
    end else if (wr_en && (wr_idx != '0)) begin
      map_next[wr_idx] = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NA); i++) map_q[i] <= PW'(i);
    end else begin
      map_q <= map_next;
    end
  end

endmodule

// File: rtl/rat_free_list.sv
module rat_free_list #(
  parameter int unsigned NA = 32,
  parameter int unsigned NP = 64,
  localparam int unsigned DEPTH = NP - NA,
  localparam int unsigned PW = $clog2(NP),
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_val,
  input  logic          rebuild,
  input  logic [NP-1:0] used,
  output logic [PW-1:0] head_val,
  output logic          empty
);

  logic [PW-1:0] mem_q   [DEPTH];
  logic [PW-1:0] mem_d   [DEPTH];
  logic [PW-1:0] reb_mem [DEPTH];
  logic [IW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d, reb_cnt;

  // ascending compaction of the unreferenced registers
  always_comb begin
    reb_cnt = '0;
    for (int i = 0; i < int'(DEPTH); i++) reb_mem[i] = '0;
    for (int p = 0; p < int'(NP); p++) begin
      if (!used[p] && (reb_cnt < CW'(DEPTH))) begin
        reb_mem[reb_cnt[IW-1:0]] = PW'(p);
        reb_cnt = reb_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    mem_d  = mem_q;
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (rebuild) begin
      mem_d  = reb_mem;
      head_d = '0;
      tail_d = (reb_cnt == CW'(DEPTH)) ? '0 : reb_cnt[IW-1:0];
      cnt_d  = reb_cnt;
    end else begin
      if (pop) begin
        head_d = (head_q == IW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
      end
      if (push) begin
        mem_d[tail_q] = push_val;
        tail_d = (tail_q == IW'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
      end
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= PW'(NA + i);
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= CW'(DEPTH);
    end else begin
      mem_q  <= mem_d;
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head_val = mem_q[head_q];
  assign empty    = (cnt_q == '0);

  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !rebuild) |-> (cnt_q != '0));
  a_r6_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !rebuild) |-> (cnt_q < CW'(DEPTH)));
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/rat_rename.sv
module rat_rename
  import rat_pkg::*;
#(
  parameter int unsigned NUM_ARCH = RAT_NUM_ARCH,
  parameter int unsigned NUM_PHYS = RAT_NUM_PHYS,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic          ren_rd_we,
  input  logic [AW-1:0] ren_rs1,
  input  logic [AW-1:0] ren_rs2,
  input  logic [AW-1:0] ren_rd,
  output logic          ren_ready,
  output logic [PW-1:0] ren_ps1,
  output logic [PW-1:0] ren_ps2,
  output logic [PW-1:0] ren_pd,
  input  logic          cmt_valid,
  input  logic [AW-1:0] cmt_rd,
  input  logic [PW-1:0] cmt_pd,
  input  logic          flush
);

  logic [NUM_ARCH-1:0][PW-1:0] spec_q, spec_next, rrat_q, rrat_next;
  logic [NUM_PHYS-1:0]         used;
  logic [PW-1:0]               fl_head, freed;
  logic                        fl_empty, need_alloc, alloc, cmt_do;

  assign need_alloc = ren_rd_we && (ren_rd != '0);
  assign ren_ready  = !flush && !(need_alloc && fl_empty);
  assign alloc      = ren_valid && ren_ready && need_alloc;
  assign cmt_do     = cmt_valid && (cmt_rd != '0);

  assign ren_ps1 = spec_q[ren_rs1];
  assign ren_ps2 = spec_q[ren_rs2];
  assign ren_pd  = need_alloc ? fl_head : '0;
  assign freed   = rrat_q[cmt_rd];

  always_comb begin
    used = '0;
    for (int a = 0; a < int'(NUM_ARCH); a++) used[rrat_next[a]] = 1'b1;
  end

  rat_map_table #(.NA(NUM_ARCH), .NP(NUM_PHYS)) u_spec (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc), .wr_idx(ren_rd), .wr_val(fl_head),
    .load_en(flush), .load_val(rrat_next),
    .map_q(spec_q), .map_next(spec_next)
  );

  rat_map_table #(.NA(NUM_ARCH), .NP(NUM_PHYS)) u_retire (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cmt_do), .wr_idx(cmt_rd), .wr_val(cmt_pd),
    .load_en(1'b0), .load_val('0),
    .map_q(rrat_q), .map_next(rrat_next)
  );

  rat_free_list #(.NA(NUM_ARCH), .NP(NUM_PHYS)) u_free (
    .clk(clk), .rst_n(rst_n),
    .pop(alloc), .push(cmt_do), .push_val(freed),
    .rebuild(flush), .used(used),
    .head_val(fl_head), .empty(fl_empty)
  );

  a_r3_alloc_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (fl_head != '0));
  a_r6_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_do |=> (rrat_q[$past(cmt_rd)] == $past(cmt_pd)));
  a_r8_flush_restore: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (spec_q == rrat_q));
  a_r8_flush_next: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (spec_next == rrat_next));
  a_r10_x0_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_rs1 == '0) |-> (ren_ps1 == '0));

endmodule

// File: tb/tb_rat_rename.sv
`timescale 1ns/1ps
module tb_rat_rename;
  localparam int NA = 32;
  localparam int NP = 64;
  localparam int DEPTH = NP - NA;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ren_valid, ren_rd_we, ren_ready, cmt_valid, flush;
  logic [4:0] ren_rs1, ren_rs2, ren_rd, cmt_rd;
  logic [5:0] ren_ps1, ren_ps2, ren_pd, cmt_pd;

  rat_rename dut (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_rd_we(ren_rd_we),
    .ren_rs1(ren_rs1), .ren_rs2(ren_rs2), .ren_rd(ren_rd),
    .ren_ready(ren_ready), .ren_ps1(ren_ps1), .ren_ps2(ren_ps2), .ren_pd(ren_pd),
    .cmt_valid(cmt_valid), .cmt_rd(cmt_rd), .cmt_pd(cmt_pd), .flush(flush)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  int spec [NA];
  int rrat [NA];
  int fq   [DEPTH];
  int fh, ft, fc;
  int iq_rd [256];
  int iq_pd [256];
  int ih, it, ic;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < NA; i++) begin spec[i] = i; rrat[i] = i; end
    for (int i = 0; i < DEPTH; i++) fq[i] = NA + i;
    fh = 0; ft = 0; fc = DEPTH;
    ih = 0; it = 0; ic = 0;
  endfunction

  function automatic void model_rebuild();
    bit u [NP];
    for (int p = 0; p < NP; p++) u[p] = 1'b0;
    for (int a = 0; a < NA; a++) u[rrat[a]] = 1'b1;
    fh = 0; fc = 0;
    for (int p = 0; p < NP; p++) if (!u[p] && fc < DEPTH) begin fq[fc] = p; fc++; end
    ft = fc % DEPTH;
  endfunction

  // one cycle; commit, when requested, retires the oldest in-flight rename
  task automatic step(bit rv, bit we, int rs1, int rs2, int rd, bit cv, bit fl,
                      bit force_x0_cmt = 1'b0, int x0_pd = 0);
    int crd, cpd, freed, pd;
    bit need, rdy, cdo;
    crd = 0; cpd = 0; cdo = 1'b0;
    if (force_x0_cmt) begin
      cdo = 1'b1; crd = 0; cpd = x0_pd;
    end else if (cv && ic > 0) begin
      cdo = 1'b1; crd = iq_rd[ih]; cpd = iq_pd[ih];
      ih = (ih + 1) % 256; ic--;
    end
    @(negedge clk);
    ren_valid = rv; ren_rd_we = we;
    ren_rs1 = 5'(rs1); ren_rs2 = 5'(rs2); ren_rd = 5'(rd);
    cmt_valid = cdo; cmt_rd = 5'(crd); cmt_pd = 6'(cpd);
    flush = fl;
    #1;
    need = we && rd != 0;
    rdy  = !fl && !(need && fc == 0);
    chk(fl ? "R8 ready" : "R5 ready", int'(ren_ready), int'(rdy));
    chk(rs1 == 0 ? "R10 ps1" : "R2 ps1", int'(ren_ps1), spec[rs1]);
    chk("R2 ps2", int'(ren_ps2), spec[rs2]);
    if (!need) chk("R4 pd", int'(ren_pd), 0);
    else if (rdy) chk("R3 R9 pd", int'(ren_pd), fq[fh]);
    @(posedge clk);
    freed = 0;
    if (cdo && crd != 0) begin freed = rrat[crd]; rrat[crd] = cpd; end
    if (fl) begin
      for (int a = 0; a < NA; a++) spec[a] = rrat[a];
      model_rebuild();
      ih = 0; it = 0; ic = 0;
    end else begin
      if (rv && rdy && need) begin
        pd = fq[fh]; fh = (fh + 1) % DEPTH; fc--;
        spec[rd] = pd;
        iq_rd[it] = rd; iq_pd[it] = pd; it = (it + 1) % 256; ic++;
      end
      if (cdo && crd != 0) begin fq[ft] = freed; ft = (ft + 1) % DEPTH; fc++; end
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    ren_valid = 0; ren_rd_we = 0; ren_rs1 = 0; ren_rs2 = 0; ren_rd = 0;
    cmt_valid = 0; cmt_rd = 0; cmt_pd = 0; flush = 0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: identity maps after reset
    for (int i = 0; i < NA; i++) begin
      @(negedge clk); ren_rs1 = 5'(i); ren_valid = 0; #1;
      chk("R1 reset map", int'(ren_ps1), i);
    end
    // R1: first allocation is 32; R2 same-cycle rs==rd reads old map
    step(1, 1, 5, 5, 5, 0, 0);
    step(1, 1, 5, 7, 7, 0, 0);
    // R4: no destination
    step(1, 0, 3, 4, 9, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    // R7: commit to x0 ignored
    step(0, 0, 0, 1, 0, 0, 0, 1'b1, 40);
    // R5: exhaust the pool without commits
    for (int k = 0; k < DEPTH + 4; k++) step(1, 1, k % NA, (k + 3) % NA, 1 + k % (NA - 1), 0, 0);
    step(1, 0, 2, 3, 4, 0, 0);
    step(1, 1, 2, 3, 0, 0, 0);
    // R6/R9: commit a few, then reallocate the released registers
    for (int k = 0; k < 5; k++) step(0, 0, k, k + 1, 0, 1, 0);
    for (int k = 0; k < 6; k++) step(1, 1, k + 10, k + 11, k + 1, 0, 0);
    // R8: flush together with a commit
    step(1, 1, 1, 2, 3, 1, 1);
    for (int a = 0; a < NA; a++) step(0, 0, a, (a + 1) % NA, 0, 0, 0);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(99));
      step(r < 75, $urandom_range(9) != 0,
           int'($urandom_range(NA - 1)), int'($urandom_range(NA - 1)),
           int'($urandom_range(NA - 1)),
           $urandom_range(99) < 45, r == 99);
    end
    step(0, 0, 0, 0, 0, 0, 1);
    for (int a = 0; a < NA; a++) step(0, 0, a, a, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule